// File: doc/BRIEF.md
# Filter Output Mode Mixer with Volume

This block builds the final audio sample of a voice-and-filter path. A three-bit mode word picks any mix of the highpass, bandpass and lowpass filter states. The picked states are added with equal weight to the unfiltered bypass sum and to a constant DC offset. The total is then scaled by a four-bit master volume. When the filter is switched off, the filter states play no part and only the bypass sum and the offset are scaled.

All operands arrive together as one input beat on a valid/ready stream. The scaled sample leaves on a second valid/ready stream from a single output register.

- An input beat is taken on any rising edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high when the output register is empty or is being drained in the same cycle. A stalled consumer therefore stops intake at once and no beat is lost.
- The output holds its value and stays valid until it is taken.

Top module: `mix_out_stage`

## Requirements
- R1: Mode bit 0 adds the lowpass state, bit 1 the bandpass state and bit 2 the highpass state, each with weight one, in any combination.
- R2: A mode word of zero adds no filter state to the sample.
- R3: The sample equals (bypass + selected filter sum + DC offset) × volume, with volume unsigned 0..15, signed and exact for all input extremes without overflow.
- R4: With `flt_en` low the filter states and mode word have no effect; the sample is (bypass + DC offset) × volume.
- R5: A volume of zero gives a sample of exactly zero.
- R6: The sample for an accepted input beat appears on `out_sample` with `out_valid` high on the clock edge after acceptance.
- R7: While `out_valid` is high and `out_ready` is low, `out_sample` and `out_valid` hold and `in_ready` is low; otherwise `in_ready` is high.
- R8: After reset `out_valid` is low and `out_sample` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| hp_in | input | W | Highpass filter state, signed |
| bp_in | input | W | Bandpass filter state, signed |
| lp_in | input | W | Lowpass filter state, signed |
| byp_in | input | W | Unfiltered bypass sum, signed |
| dc_in | input | W | DC offset, signed |
| mode_in | input | 3 | Filter output select (bit0 low, bit1 band, bit2 high) |
| vol_in | input | 4 | Master volume, unsigned |
| flt_en | input | 1 | Filter enable |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Consumer takes the sample |
| out_sample | output | W+7 | Scaled sample, signed |

## Verification
- `in_ready` depends only on the current output state and `out_ready`, so it is due in the same cycle.
- A sample is due exactly one edge after its beat is accepted. During a stall it is due unchanged on every edge until it is taken.
- The reference model advances once per rising edge. It predicts the output register from the inputs held stable across that edge.
- Outputs are compared at every falling edge, and new stimulus is applied only after that comparison.

// File: rtl/mix_out_pkg.sv
package mix_out_pkg;
  localparam int MODE_BITS = 3;
  localparam int VOL_BITS  = 4;
  localparam int TAP_LP    = 0;
  localparam int TAP_BP    = 1;
  localparam int TAP_HP    = 2;
  localparam int SUM_GROW  = 3;
endpackage

// File: rtl/mix_tap_sum.sv
module mix_tap_sum #(
  parameter int W = 16
) (
  input  logic signed [W-1:0]                         lp_in,
  input  logic signed [W-1:0]                         bp_in,
  input  logic signed [W-1:0]                         hp_in,
  input  logic [mix_out_pkg::MODE_BITS-1:0]           mode_in,
  input  logic                                        flt_en,
  output logic signed [W+1:0]                         tap_sum
);
  import mix_out_pkg::*;
  localparam int TW = W + 2;

  logic signed [W-1:0] taps [MODE_BITS];
  logic signed [TW-1:0] gated [MODE_BITS];

  assign taps[TAP_LP] = lp_in;
  assign taps[TAP_BP] = bp_in;
  assign taps[TAP_HP] = hp_in;

  for (genvar i = 0; i < MODE_BITS; i++) begin : g_tap
    always_comb begin
      if (flt_en && mode_in[i]) gated[i] = TW'(taps[i]);
      else                      gated[i] = '0;
    end
  end

  always_comb begin
    tap_sum = '0;
    for (int i = 0; i < MODE_BITS; i++) tap_sum = tap_sum + gated[i];
  end
endmodule

// File: rtl/mix_vol_scale.sv
module mix_vol_scale #(
  parameter int SW = 19,
  parameter int VW = 4
) (
  input  logic signed [SW-1:0] sum_in,
  input  logic [VW-1:0]        vol_in,
  output logic signed [SW+VW-1:0] prod
);
  localparam int PW = SW + VW + 1;
  logic signed [PW-1:0] full;
  logic signed [VW:0]   vol_s;

  assign vol_s = $signed({1'b0, vol_in});
  assign full  = PW'(sum_in) * PW'(vol_s);
  assign prod  = full[SW+VW-1:0];
endmodule

// File: rtl/mix_out_stage.sv
module mix_out_stage #(
  parameter int W = 16,
  localparam int OW = W + mix_out_pkg::SUM_GROW + mix_out_pkg::VOL_BITS
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   in_valid,
  output logic                                   in_ready,
  input  logic signed [W-1:0]                    hp_in,
  input  logic signed [W-1:0]                    bp_in,
  input  logic signed [W-1:0]                    lp_in,
  input  logic signed [W-1:0]                    byp_in,
  input  logic signed [W-1:0]                    dc_in,
  input  logic [mix_out_pkg::MODE_BITS-1:0]      mode_in,
  input  logic [mix_out_pkg::VOL_BITS-1:0]       vol_in,
  input  logic                                   flt_en,
  output logic                                   out_valid,
  input  logic                                   out_ready,
  output logic signed [OW-1:0]                   out_sample
);
  import mix_out_pkg::*;
  localparam int SW = W + SUM_GROW;

  logic signed [W+1:0]  tap_sum;
  logic signed [SW-1:0] total;
  logic signed [OW-1:0] scaled;
  logic                 take;

  mix_tap_sum #(.W(W)) u_taps (
    .lp_in(lp_in), .bp_in(bp_in), .hp_in(hp_in),
    .mode_in(mode_in), .flt_en(flt_en), .tap_sum(tap_sum)
  );

  assign total = SW'(byp_in) + SW'(dc_in) + SW'(tap_sum);

  mix_vol_scale #(.SW(SW), .VW(VOL_BITS)) u_scale (
    .sum_in(total), .vol_in(vol_in), .prod(scaled)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_sample <= scaled;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/mix_out_stage_chk.sv
module mix_out_stage_chk #(
  parameter int W = 16,
  parameter int OW = W + 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic signed [W-1:0]  byp_in,
  input logic signed [W-1:0]  dc_in,
  input logic [3:0]           vol_in,
  input logic                 flt_en,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [OW-1:0] out_sample
);
  logic signed [OW-1:0] byp_only;
  assign byp_only = (OW'(byp_in) + OW'(dc_in)) * OW'($signed({1'b0, vol_in}));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sample));

  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_vol_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && vol_in == 4'd0 |=> out_sample == '0);

  p_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !flt_en |=> out_sample == $past(byp_only));

  p_reset_r8: assert property (@(posedge clk)
    !rst_n |-> !out_valid && out_sample == '0);
endmodule

bind mix_out_stage mix_out_stage_chk #(.W(W), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .byp_in(byp_in), .dc_in(dc_in), .vol_in(vol_in), .flt_en(flt_en),
  .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample)
);

// File: tb/mix_out_stage_tb.sv
`timescale 1ns/1ps
module mix_out_stage_tb;
  localparam int W  = 16;
  localparam int OW = W + 7;
  localparam longint MAXV = (64'sd1 <<< (W-1)) - 1;
  localparam longint MINV = -(64'sd1 <<< (W-1));

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0, flt_en = 0;
  logic signed [W-1:0] hp_in = 0, bp_in = 0, lp_in = 0, byp_in = 0, dc_in = 0;
  logic [2:0] mode_in = 0;
  logic [3:0] vol_in = 0;
  logic in_ready, out_valid;
  logic signed [OW-1:0] out_sample;

  int checks = 0, errors = 0;
  bit exp_valid = 0;
  longint exp_sample = 0;
  string cur_req = "R8";
  bit done = 0;

  always #5 clk = ~clk;

  mix_out_stage #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .hp_in(hp_in), .bp_in(bp_in), .lp_in(lp_in), .byp_in(byp_in), .dc_in(dc_in),
    .mode_in(mode_in), .vol_in(vol_in), .flt_en(flt_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample)
  );

  function automatic longint model_sample();
    longint f = 0;
    if (flt_en) begin
      if (mode_in[0]) f += longint'(lp_in);
      if (mode_in[1]) f += longint'(bp_in);
      if (mode_in[2]) f += longint'(hp_in);
    end
    return (longint'(byp_in) + f + longint'(dc_in)) * longint'(vol_in);
  endfunction

  task automatic compare();
    longint act = longint'(out_sample);
    bit exp_rdy = !exp_valid || out_ready;
    checks++;
    if (out_valid !== exp_valid) begin
      errors++;
      $display("FAIL %s out_valid actual=%0d expected=%0d", cur_req, out_valid, exp_valid);
    end
    checks++;
    if (act != exp_sample) begin
      errors++;
      $display("FAIL %s out_sample actual=%0d expected=%0d", cur_req, act, exp_sample);
    end
    checks++;
    if (in_ready !== exp_rdy) begin
      errors++;
      $display("FAIL R7 in_ready actual=%0d expected=%0d", in_ready, exp_rdy);
    end
  endtask

  // model advances with inputs that will be sampled at the coming edge
  task automatic advance();
    bit rdy = !exp_valid || out_ready;
    if (in_valid && rdy) begin
      exp_valid  = 1;
      exp_sample = model_sample();
    end else if (out_ready) exp_valid = 0;
  endtask

  task automatic beat(string req, bit v, bit ordy, bit en, logic [2:0] m, logic [3:0] vol,
                      longint lp, longint bp, longint hp, longint byp, longint dc);
    @(negedge clk);
    compare();
    cur_req  = req;
    in_valid = v; out_ready = ordy; flt_en = en; mode_in = m; vol_in = vol;
    lp_in = W'(lp); bp_in = W'(bp); hp_in = W'(hp); byp_in = W'(byp); dc_in = W'(dc);
    advance();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R8";
    compare();
    rst_n = 1;
    // R1: each mode combination, distinct tap values
    for (int m = 0; m < 8; m++)
      beat(m == 0 ? "R2" : "R1", 1, 1, 1, 3'(m), 4'd7, 100, -250, 3000, 40, -12);
    // R2: mode zero with large filter states
    beat("R2", 1, 1, 1, 3'd0, 4'd15, MAXV, MAXV, MAXV, 5, 6);
    // R3: extremes
    beat("R3", 1, 1, 1, 3'd7, 4'd15, MINV, MINV, MINV, MINV, MINV);
    beat("R3", 1, 1, 1, 3'd7, 4'd15, MAXV, MAXV, MAXV, MAXV, MAXV);
    beat("R3", 1, 1, 1, 3'd5, 4'd1, MAXV, MINV, MAXV, MINV, 1);
    // R4: disabled filter ignores taps and mode
    beat("R4", 1, 1, 0, 3'd7, 4'd9, 1111, 2222, 3333, -700, 55);
    beat("R4", 1, 1, 0, 3'd3, 4'd15, MINV, MAXV, MINV, MAXV, MAXV);
    // R5: volume zero
    beat("R5", 1, 1, 1, 3'd7, 4'd0, MAXV, MAXV, MAXV, MAXV, MAXV);
    beat("R5", 1, 1, 0, 3'd1, 4'd0, MINV, 1, 1, MINV, MINV);
    // R6: idle then single beat
    beat("R6", 0, 1, 1, 3'd1, 4'd3, 9, 9, 9, 9, 9);
    beat("R6", 1, 1, 1, 3'd2, 4'd3, 1, 20, 300, -4, 2);
    beat("R6", 0, 1, 1, 3'd2, 4'd3, 1, 20, 300, -4, 2);
    // R7: back-pressure, new beats offered while stalled
    beat("R7", 1, 0, 1, 3'd4, 4'd2, 0, 0, 123, 1, 1);
    for (int i = 0; i < 4; i++)
      beat("R7", 1, 0, 1, 3'd4, 4'd5, 0, 0, 999 + i, 7, 7);
    beat("R7", 1, 1, 1, 3'd1, 4'd11, -77, 0, 0, 3, 3);
    beat("R7", 0, 0, 1, 3'd1, 4'd11, 0, 0, 0, 0, 0);
    beat("R7", 0, 1, 1, 3'd1, 4'd11, 0, 0, 0, 0, 0);
    // mixed stream
    for (int i = 0; i < 300; i++)
      beat("R3", 1'($urandom), 1'($urandom), 1'($urandom), 3'($urandom), 4'($urandom),
           longint'($signed(W'($urandom))), longint'($signed(W'($urandom))),
           longint'($signed(W'($urandom))), longint'($signed(W'($urandom))),
           longint'($signed(W'($urandom))));
    @(negedge clk);
    compare();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule